// File: doc/BRIEF.md
# Serial Flash Identification and Discovery Responder

This block is the read-only answering stage of a serial-flash slave model. A shift front end hands it whole bytes. Each byte written by the host arrives as a `wr_vld` strobe with `wr_byte`. Each byte the host wants to read arrives as an `rd_req` strobe, one per read slot. Chip select `cs_n` frames a transaction. The block answers four commands, one response byte per read slot: the electronic signature, the manufacturer/device pair, the three-byte JEDEC identity, and the discovery parameter table. The discovery table is an 88-byte constant ROM.

The block counts write bytes and read slots itself, and raising `cs_n` clears both counts. A response depends on the opcode, the 24-bit address, the number of write bytes clocked, and the read slot index. The discovery read absorbs a missing dummy byte from the read phase. Extra write bytes after the dummy shift the table offset. The start address wraps at the table size. Any read slot with no defined answer returns 0xFF.

Top module: `flashid_responder`

## Requirements
- R1: After reset, `rsp_vld` is 0 and `rsp_data` is 0xFF. In every cycle where `rsp_vld` is 0, `rsp_data` is 0xFF.
- R2: An `rd_req` sampled while `cs_n` is low produces `rsp_vld` = 1 with the answer byte on the next clock edge, and only then. An `rd_req` sampled while `cs_n` is high produces nothing.
- R3: While `cs_n` is high, the write count, the read count, the opcode and the address all return to zero, so each framed transaction starts fresh.
- R4: Opcode 0xAB returns the signature byte `SIG_ID` in every read slot, provided at least four write bytes were clocked. With fewer than four write bytes it returns 0xFF.
- R5: Opcode 0x90 returns byte `(A + (W-4) + i) mod 2` of the pair {`MFR_ID`, `MDID_DEV`}, where A is the address, W is the write count (at least 4) and i is the read slot index. With W below 4 it returns 0xFF.
- R6: Opcode 0x9F returns `MFR_ID`, `JID_TYPE` and `JID_CAP` in read slots 0, 1 and 2, and 0xFF in every later slot.
- R7: Opcode 0x5A with W ≥ 5 write bytes (opcode, three big-endian address bytes, dummy, then extras) returns table byte `start + i` in slot i, where `start = (A + W - 5) mod 88`. Table bytes 0 to 3 are 0x53, 0x46, 0x44, 0x50.
- R8: Opcode 0x5A with exactly W = 4 returns 0xFF in slot 0, which stands for the dummy byte, and returns table byte `(A mod 88) + i - 1` in slot i ≥ 1. With W < 4 every slot returns 0xFF.
- R9: A discovery start address at or beyond 88 is reduced modulo 88 before any data is returned.
- R10: Discovery slots whose table position reaches 88 or more return 0xFF.
- R11: Any other opcode, including an empty frame, returns 0xFF in every slot.
- R12: A write byte is dropped, and does not count toward W, if it arrives in the same cycle as a read slot or after the first read slot of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| wr_vld | input | 1 | Write byte valid strobe |
| wr_byte | input | 8 | Byte written by the host |
| rd_req | input | 1 | One read slot requested |
| rsp_vld | output | 1 | Response byte valid, one cycle after `rd_req` |
| rsp_data | output | 8 | Response byte, 0xFF when idle |

## Verification
A write strobe and a read strobe can land in the same cycle. In that case the read slot must be answered from the state before the write, and the write byte must be lost. The bench provokes this in a discovery frame that has no dummy byte. It asserts both strobes together, then checks that the slot still acts as the absorbed dummy (0xFF) and that the next slot starts at table byte 0 and not byte 1. A further write after reading has begun is then shown to leave the offset unshifted.

// File: rtl/flashid_pkg.sv
package flashid_pkg;
    localparam int TBL_BYTES = 88;
    localparam int TBL_AW    = $clog2(TBL_BYTES);
    localparam int CNT_W     = 8;
    localparam int ADR_W     = 24;

    localparam logic [7:0] OP_DISC = 8'h5A;
    localparam logic [7:0] OP_MDID = 8'h90;
    localparam logic [7:0] OP_JID  = 8'h9F;
    localparam logic [7:0] OP_SIG  = 8'hAB;
    localparam logic [7:0] NO_DATA = 8'hFF;

    typedef struct packed {
        logic [7:0]       op;
        logic [ADR_W-1:0] adr;
        logic [CNT_W-1:0] wn;
        logic [CNT_W-1:0] rn;
        logic             rd_ph;
    } cap_t;

    typedef struct packed {
        logic       vld;
        logic [7:0] dat;
    } rsp_t;
endpackage

// File: rtl/flashid_disc_rom.sv
module flashid_disc_rom
    import flashid_pkg::*;
#(
    parameter int AW = TBL_AW
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    dat
);
    always_comb begin
        case (idx)
            7'h00: dat = 8'h53;
            7'h01: dat = 8'h46;
            7'h02: dat = 8'h44;
            7'h03: dat = 8'h50;
            7'h04, 7'h08, 7'h09, 7'h0D, 7'h0E, 7'h11, 7'h15, 7'h16,
            7'h24, 7'h2A, 7'h32, 7'h33, 7'h36, 7'h3E, 7'h48, 7'h4A: dat = 8'h00;
            7'h05, 7'h06, 7'h0A, 7'h12: dat = 8'h01;
            7'h0B: dat = 8'h09;
            7'h0C: dat = 8'h1C;
            7'h10: dat = 8'hC2;
            7'h13: dat = 8'h04;
            7'h14: dat = 8'h48;
            7'h1C: dat = 8'hE5;
            7'h1D, 7'h39: dat = 8'h20;
            7'h1E: dat = 8'hC9;
            7'h23: dat = 8'h03;
            7'h26, 7'h28: dat = 8'h08;
            7'h27: dat = 8'h6B;
            7'h29: dat = 8'h3B;
            7'h2C: dat = 8'hEE;
            7'h38: dat = 8'h0C;
            7'h3A: dat = 8'h0F;
            7'h3B: dat = 8'h52;
            7'h3C: dat = 8'h10;
            7'h3D: dat = 8'hD8;
            7'h49: dat = 8'h36;
            7'h4B: dat = 8'h27;
            7'h4C: dat = 8'hF4;
            7'h4D: dat = 8'h4F;
            7'h50: dat = 8'hD9;
            7'h51: dat = 8'hC8;
            default: dat = NO_DATA;
        endcase
    end
endmodule

// File: rtl/flashid_cmd_capture.sv
module flashid_cmd_capture
    import flashid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_vld,
    input  logic [7:0] wr_byte,
    input  logic rd_req,
    output cap_t cap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (cs_n) begin
            cap_d = '0;
        end else if (rd_req) begin
            cap_d.rd_ph = 1'b1;
            if (cap_q.rn != CNT_MAX) cap_d.rn = cap_q.rn + 1'b1;
        end else if (wr_vld && !cap_q.rd_ph) begin
            if (cap_q.wn == '0) cap_d.op = wr_byte;
            if (cap_q.wn >= CNT_W'(1) && cap_q.wn <= CNT_W'(3))
                cap_d.adr = {cap_q.adr[ADR_W-9:0], wr_byte};
            if (cap_q.wn != CNT_MAX) cap_d.wn = cap_q.wn + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap = cap_q;
endmodule

// File: rtl/flashid_responder.sv
module flashid_responder
    import flashid_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MDID_DEV = 8'h16,
    parameter logic [7:0] JID_TYPE = 8'h20,
    parameter logic [7:0] JID_CAP  = 8'h17,
    parameter logic [7:0] SIG_ID   = 8'h16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wr_vld,
    input  logic [7:0] wr_byte,
    input  logic       rd_req,
    output logic       rsp_vld,
    output logic [7:0] rsp_data
);
    localparam int SUM_W = ADR_W + 1;
    localparam int POS_W = CNT_W + 2;

    cap_t cap;
    rsp_t rsp_d, rsp_q;

    logic             has_adr;
    logic             no_dummy;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] base_mod;
    logic [CNT_W-1:0] slot;
    logic [POS_W-1:0] pos;
    logic [7:0]       rom_dat;

    flashid_cmd_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_vld  (wr_vld),
        .wr_byte (wr_byte),
        .rd_req  (rd_req),
        .cap     (cap)
    );

    always_comb begin
        has_adr  = (cap.wn >= CNT_W'(4));
        no_dummy = (cap.wn == CNT_W'(4));
        if (no_dummy) base = {1'b0, cap.adr};
        else          base = {1'b0, cap.adr} + SUM_W'(cap.wn) - SUM_W'(5);
        base_mod = base % SUM_W'(TBL_BYTES);
        slot     = no_dummy ? cap.rn - 1'b1 : cap.rn;
        pos      = POS_W'(base_mod[TBL_AW-1:0]) + POS_W'(slot);
    end

    flashid_disc_rom #(.AW(TBL_AW)) u_rom (
        .idx (pos[TBL_AW-1:0]),
        .dat (rom_dat)
    );

    always_comb begin
        rsp_d.vld = 1'b0;
        rsp_d.dat = NO_DATA;
        if (rd_req && !cs_n) begin
            rsp_d.vld = 1'b1;
            case (cap.op)
                OP_SIG: if (has_adr) rsp_d.dat = SIG_ID;
                OP_MDID: if (has_adr)
                    rsp_d.dat = (cap.adr[0] ^ cap.wn[0] ^ cap.rn[0]) ? MDID_DEV : MFR_ID;
                OP_JID: begin
                    if (cap.rn == CNT_W'(0))      rsp_d.dat = MFR_ID;
                    else if (cap.rn == CNT_W'(1)) rsp_d.dat = JID_TYPE;
                    else if (cap.rn == CNT_W'(2)) rsp_d.dat = JID_CAP;
                end
                OP_DISC: begin
                    if (has_adr && !(no_dummy && cap.rn == '0) &&
                        pos < POS_W'(TBL_BYTES))
                        rsp_d.dat = rom_dat;
                end
                default: rsp_d.dat = NO_DATA;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{vld: 1'b0, dat: NO_DATA};
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld  = rsp_q.vld;
    assign rsp_data = rsp_q.dat;
endmodule

// File: rtl/flashid_responder_chk.sv
module flashid_responder_chk #(
    parameter logic [7:0] SIG_ID = 8'h16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wr_vld,
    input logic [7:0] wr_byte,
    input logic       rd_req,
    input logic       rsp_vld,
    input logic [7:0] rsp_data
);
    logic [7:0] op_c;
    logic [2:0] wn_c;
    logic       rph_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_c <= '0; wn_c <= '0; rph_c <= 1'b0;
        end else if (cs_n) begin
            op_c <= '0; wn_c <= '0; rph_c <= 1'b0;
        end else if (rd_req) begin
            rph_c <= 1'b1;
        end else if (wr_vld && !rph_c) begin
            if (wn_c == 3'd0) op_c <= wr_byte;
            if (wn_c != 3'd7) wn_c <= wn_c + 3'd1;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !cs_n) |=> rsp_vld);
    // R2
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(rd_req && !cs_n));
    // R1
    idle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> rsp_data == 8'hFF);
    // R4
    sig_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && $past(op_c == 8'hAB && wn_c >= 3'd4)) |-> rsp_data == SIG_ID);
    // R11
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && $past(op_c != 8'hAB && op_c != 8'h90 && op_c != 8'h9F && op_c != 8'h5A))
        |-> rsp_data == 8'hFF);
endmodule

bind flashid_responder flashid_responder_chk #(.SIG_ID(SIG_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_vld   (wr_vld),
    .wr_byte  (wr_byte),
    .rd_req   (rd_req),
    .rsp_vld  (rsp_vld),
    .rsp_data (rsp_data)
);

// File: tb/flashid_responder_tb.sv
`timescale 1ns/1ps
module flashid_responder_tb;
    localparam logic [7:0] MFR = 8'hC2, DEV = 8'h16, TYP = 8'h20, CAP = 8'h17, SIG = 8'h16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic wr_vld = 1'b0;
    logic [7:0] wr_byte = '0;
    logic rd_req = 1'b0;
    logic rsp_vld;
    logic [7:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    flashid_responder u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_vld(wr_vld),
        .wr_byte(wr_byte), .rd_req(rd_req), .rsp_vld(rsp_vld), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] tbl(input int i);
        case (i)
            0: return 8'h53; 1: return 8'h46; 2: return 8'h44; 3: return 8'h50;
            4, 8, 9, 13, 14, 17, 21, 22, 36, 42, 50, 51, 54, 62, 72, 74: return 8'h00;
            5, 6, 10, 18: return 8'h01;
            11: return 8'h09; 12: return 8'h1C; 16: return 8'hC2; 19: return 8'h04;
            20: return 8'h48; 28: return 8'hE5; 29, 57: return 8'h20; 30: return 8'hC9;
            35: return 8'h03; 38, 40: return 8'h08; 39: return 8'h6B; 41: return 8'h3B;
            44: return 8'hEE; 56: return 8'h0C; 58: return 8'h0F; 59: return 8'h52;
            60: return 8'h10; 61: return 8'hD8; 73: return 8'h36; 75: return 8'h27;
            76: return 8'hF4; 77: return 8'h4F; 80: return 8'hD9; 81: return 8'hC8;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        wr_vld = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d, output logic v);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = rsp_vld; d = rsp_data;
    endtask

    task automatic cmd(input logic [7:0] op, input logic [23:0] a, input int nw);
        cs_n = 1'b0;
        for (int k = 0; k < nw; k++) begin
            case (k)
                0: wr(op);
                1: wr(a[23:16]);
                2: wr(a[15:8]);
                3: wr(a[7:0]);
                default: wr(8'h00);
            endcase
        end
    endtask

    task automatic close;
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset vld", {7'b0, rsp_vld}, 8'h00);
        chk("R1 reset data", rsp_data, 8'hFF);

        // R2: read slot while deselected gives nothing
        cs_n = 1'b1;
        rd(d, v);
        chk("R2 deselected read", {7'b0, v}, 8'h00);

        // R7 R9 R10: discovery sweep with one dummy, address 0..100
        for (int a = 0; a <= 100; a++) begin
            cmd(8'h5A, 24'(a), 5);
            for (int i = 0; i < 4; i++) begin
                int p;
                rd(d, v);
                p = (a % 88) + i;
                if (i == 0) chk("R2 slot valid", {7'b0, v}, 8'h01);
                chk(a >= 88 ? "R9 wrapped start" : (p >= 88 ? "R10 past end" : "R7 table data"),
                    d, p < 88 ? tbl(p) : 8'hFF);
            end
            @(negedge clk);
            chk("R1 idle data", rsp_data, 8'hFF);
            close();
        end

        // R7: extra write bytes shift the offset
        for (int w = 5; w <= 9; w++) begin
            cmd(8'h5A, 24'h000050, w);
            for (int i = 0; i < 3; i++) begin
                int p;
                rd(d, v);
                p = ((80 + w - 5) % 88) + i;
                chk("R7 extra bytes", d, p < 88 ? tbl(p) : 8'hFF);
            end
            close();
        end

        // R8: no dummy byte, first slot absorbed
        for (int a = 0; a < 90; a += 7) begin
            cmd(8'h5A, 24'(a), 4);
            for (int i = 0; i < 3; i++) begin
                int p;
                rd(d, v);
                p = (a % 88) + i - 1;
                chk("R8 absorbed dummy", d, (i == 0 || p >= 88) ? 8'hFF : tbl(p));
            end
            close();
        end
        // R8: too few write bytes
        cmd(8'h5A, 24'h0, 3);
        rd(d, v); chk("R8 short frame", d, 8'hFF);
        close();

        // R5: manufacturer/device pair parity
        for (int a = 0; a < 4; a++)
            for (int w = 3; w <= 6; w++) begin
                cmd(8'h90, 24'(a), w);
                for (int i = 0; i < 4; i++) begin
                    rd(d, v);
                    chk("R5 pair", d, w < 4 ? 8'hFF : (((a + w - 4 + i) % 2) != 0 ? DEV : MFR));
                end
                close();
            end

        // R4: signature
        for (int w = 1; w <= 5; w++) begin
            cmd(8'hAB, 24'h123456, w);
            for (int i = 0; i < 3; i++) begin
                rd(d, v);
                chk("R4 signature", d, w < 4 ? 8'hFF : SIG);
            end
            close();
        end

        // R6 R3: JEDEC identity, slot count restarts per frame
        for (int f = 0; f < 2; f++) begin
            cmd(8'h9F, 24'h0, 1);
            for (int i = 0; i < 5; i++) begin
                rd(d, v);
                chk(f == 0 ? "R6 jedec id" : "R3 fresh frame", d,
                    i == 0 ? MFR : i == 1 ? TYP : i == 2 ? CAP : 8'hFF);
            end
            close();
        end

        // R11: unknown opcodes and empty frame
        for (int op = 0; op < 256; op += 17) begin
            if (op == 8'h5A || op == 8'h90 || op == 8'h9F || op == 8'hAB) continue;
            cmd(8'(op), 24'h000000, 5);
            rd(d, v); chk("R11 unknown opcode", d, 8'hFF);
            close();
        end
        cs_n = 1'b0;
        rd(d, v); chk("R11 empty frame", d, 8'hFF);
        close();

        // R12: write together with read, and write after read
        cmd(8'h5A, 24'h000000, 4);
        wr_vld = 1'b1; wr_byte = 8'h00; rd_req = 1'b1;
        @(negedge clk);
        wr_vld = 1'b0; rd_req = 1'b0;
        chk("R12 same-cycle slot", rsp_data, 8'hFF);
        rd(d, v); chk("R12 same-cycle write dropped", d, 8'h53);
        wr(8'h00);
        rd(d, v); chk("R12 late write dropped", d, 8'h46);
        close();

        // R3: address cleared by deselect
        cmd(8'h5A, 24'h000010, 5);
        close();
        cs_n = 1'b0;
        wr(8'h5A);
        rd(d, v); chk("R3 counters cleared", d, 8'hFF);
        close();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule